// File: doc/BRIEF.md
# Potentiometer Wiper Register Bank

This block keeps the digital state behind one or two 256-step potentiometer channels: an 8-bit wiper code per channel, two general-purpose logic output latches, and the shutdown state that tells the analog side to open the top terminal and tie the wiper to the bottom terminal. A serial front end decodes bus traffic and presents each write as a single-cycle strobe. The strobe carries a channel select, a midscale-reset bit, a shutdown bit, two output-latch bits and an 8-bit data value.

Shutdown comes from two sources. One is the latched shutdown bit of the last write. The other is an active-low pin that takes effect without any clock. Neither source alters a stored wiper code, so the previous setting returns when shutdown ends. A readback port always shows the stored code of the channel named by the most recent write, even while the device is shut down. Each channel also raises a one-cycle flag whenever its code actually changes.

Top module: `wpot_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every wiper code presets to midscale 0x80, both logic outputs and the change flags clear, the software shutdown latch clears, and the remembered channel returns to channel 0.
- R2: A write with the midscale bit low loads `cmd_data` into the selected channel, visible at the first clock edge after the strobe. Channels that are not selected keep their codes, and no code changes without a write.
- R3: A write with the midscale bit high loads 0x80 into the selected channel and ignores `cmd_data`.
- R4: In the two-channel build, `cmd_sel`=0 addresses channel 0 (bits 7:0 of `wiper_code`) and `cmd_sel`=1 addresses channel 1 (bits 15:8). In the one-channel build, `cmd_sel` has no effect and every write reaches channel 0.
- R5: A write with the shutdown bit high raises `sd_active` after that edge. The shutdown stays active until a later write carries the shutdown bit low.
- R6: Driving `shdn_n` low raises `sd_active` without a clock edge. Releasing it drops `sd_active` again unless the software latch is set.
- R7: No shutdown source changes any stored code or the readback, so each channel shows its earlier code when shutdown ends.
- R8: Every write loads `cmd_o1` and `cmd_o2` into `gpo1` and `gpo2`, whichever channel is selected.
- R9: `code_vld[i]` is high for exactly the one cycle after a write that changed channel i's code. A write of the code already held does not raise it.
- R10: `rd_data` shows the stored code of the channel selected by the most recent write, and it does so during shutdown as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | One-cycle write command strobe |
| cmd_sel | input | SEL_W (1) | Channel select of the command |
| cmd_mid | input | 1 | Midscale reset bit of the command |
| cmd_sd | input | 1 | Software shutdown bit of the command |
| cmd_o1 | input | 1 | Value for logic output 1 |
| cmd_o2 | input | 1 | Value for logic output 2 |
| cmd_data | input | CODE_W (8) | Wiper data of the command |
| shdn_n | input | 1 | Active-low asynchronous shutdown pin |
| wiper_code | output | NUM_CH*CODE_W (16) | Stored wiper codes, channel 0 in the low byte |
| code_vld | output | NUM_CH (2) | Per-channel code-changed pulse |
| sd_active | output | 1 | Shutdown: open terminal A, wiper tied to B |
| gpo1 | output | 1 | Logic output latch 1 |
| gpo2 | output | 1 | Logic output latch 2 |
| rd_data | output | CODE_W (8) | Readback of the last-selected channel |

## Verification
Codes, change flags, logic outputs, the software shutdown state and readback all settle one clock edge after the write strobe. The pin path to `sd_active` settles with no clock edge at all. The bench drives every input on the falling edge and checks at the following falling edge, so each registered result is sampled exactly one rising edge after its cause. The change flag is checked once more a cycle later to confirm that it has dropped. The pin is checked one nanosecond after it moves, well before the next rising edge, which shows that the pin path does not wait for the clock.

// File: rtl/wpot_pkg.sv
// Package: shared constants and the decoded control-field type for the
// wiper register bank. Assumes 8-bit codes unless a module overrides CODE_W.
package wpot_pkg;
    localparam int CODE_W_DEF = 8;

    // Control bits of one write command, excluding data and select
    typedef struct packed {
        logic mid;
        logic sd;
        logic o1;
        logic o2;
    } wpot_ctl_t;
endpackage

// File: rtl/wpot_chan.sv
// Module: one wiper channel register. Loads data or midscale on a write,
// presets to midscale on reset, and pulses vld for one cycle when the
// stored code changes. Assumes wr_en is already qualified by channel select.
module wpot_chan #(
    parameter int CODE_W = 8,
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              mid,
    input  logic [CODE_W-1:0] data,
    output logic [CODE_W-1:0] code,
    output logic              vld
);
    logic [CODE_W-1:0] next_code;

    // Select the value to load: midscale wins over data
    always_comb next_code = mid ? MID : data;

    // Hold the code and produce the one-cycle change pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= MID;
            vld  <= 1'b0;
        end else begin
            vld <= 1'b0;
            if (wr_en) begin
                code <= next_code;
                vld  <= (next_code != code);
            end
        end
    end

    AST_MID_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mid) |=> (code == MID)); // R3
    AST_HOLD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(code)); // R2
    AST_VLD_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code) |-> vld); // R9
endmodule

// File: rtl/wpot_shdn.sv
// Module: shutdown merge. Keeps the software shutdown latch, written on
// every command, and ORs it with the inverted pin, which needs no clock.
// Assumes the pin is glitch-free at board level.
module wpot_shdn (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic sd_bit,
    input  logic pin_n,
    output logic sd_active
);
    logic sd_sw;

    // Latch the software shutdown bit on each write
    always_ff @(posedge clk) begin
        if (!rst_n) sd_sw <= 1'b0;
        else if (wr_en) sd_sw <= sd_bit;
    end

    // Merge software latch and asynchronous pin
    always_comb sd_active = sd_sw | ~pin_n;

    AST_SD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sd_bit) |=> sd_active); // R5
    AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sd_sw)); // R5
endmodule

// File: rtl/wpot_ctl.sv
// Module: logic output latches and last-selected channel memory. Both load
// on every write. A select outside the channel range is not remembered.
module wpot_ctl #(
    parameter int NUM_CH = 2,
    parameter int SEL_W  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    input  logic             o1_in,
    input  logic             o2_in,
    output logic             o1,
    output logic             o2,
    output logic [SEL_W-1:0] sel_q
);
    // Load the output latches and the remembered channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o1    <= 1'b0;
            o2    <= 1'b0;
            sel_q <= '0;
        end else if (wr_en) begin
            o1 <= o1_in;
            o2 <= o2_in;
            if (32'(sel) < NUM_CH) sel_q <= sel;
        end
    end

    AST_GPO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (o1 == $past(o1_in)) && (o2 == $past(o2_in))); // R8
endmodule

// File: rtl/wpot_bank.sv
// Module: top of the wiper register bank. Routes write commands to the
// channel registers, the shutdown merge and the control latches, and
// muxes readback. Assumes cmd_wr is a one-cycle strobe in the clk domain.
module wpot_bank
    import wpot_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CODE_W = CODE_W_DEF,
    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_wr,
    input  logic [SEL_W-1:0]         cmd_sel,
    input  logic                     cmd_mid,
    input  logic                     cmd_sd,
    input  logic                     cmd_o1,
    input  logic                     cmd_o2,
    input  logic [CODE_W-1:0]        cmd_data,
    input  logic                     shdn_n,
    output logic [NUM_CH*CODE_W-1:0] wiper_code,
    output logic [NUM_CH-1:0]        code_vld,
    output logic                     sd_active,
    output logic                     gpo1,
    output logic                     gpo2,
    output logic [CODE_W-1:0]        rd_data
);
    wpot_ctl_t         ctl;
    logic [SEL_W-1:0]  eff_sel;
    logic [SEL_W-1:0]  sel_q;
    logic [CODE_W-1:0] code_a [NUM_CH];

    // Pack the command control bits
    always_comb ctl = '{mid: cmd_mid, sd: cmd_sd, o1: cmd_o1, o2: cmd_o2};

    // Single-channel build ignores the select input
    generate
        if (NUM_CH == 1) begin : g_one
            always_comb eff_sel = '0;
        end else begin : g_many
            always_comb eff_sel = cmd_sel;
        end
    endgenerate

    // One register per channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic wr_ch;
        always_comb wr_ch = cmd_wr && (eff_sel == SEL_W'(ch));
        wpot_chan #(.CODE_W(CODE_W)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_ch),
            .mid   (ctl.mid),
            .data  (cmd_data),
            .code  (code_a[ch]),
            .vld   (code_vld[ch])
        );
        always_comb wiper_code[ch*CODE_W +: CODE_W] = code_a[ch];
    end

    wpot_shdn u_shdn (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cmd_wr),
        .sd_bit    (ctl.sd),
        .pin_n     (shdn_n),
        .sd_active (sd_active)
    );

    wpot_ctl #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cmd_wr),
        .sel   (eff_sel),
        .o1_in (ctl.o1),
        .o2_in (ctl.o2),
        .o1    (gpo1),
        .o2    (gpo2),
        .sel_q (sel_q)
    );

    // Readback of the last-selected channel
    always_comb rd_data = code_a[sel_q];

    AST_RD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_wr && $past(!cmd_wr)) |-> $stable(rd_data)); // R10
    AST_PIN_SD: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |-> sd_active); // R6
endmodule

// File: tb/tb_wpot_bank.sv
// Directed bench for the wiper register bank: one task per scenario, with
// a second single-channel instance sharing the command inputs.
module tb_wpot_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [0:0]  cmd_sel = 1'b0;
    logic        cmd_mid = 1'b0, cmd_sd = 1'b0, cmd_o1 = 1'b0, cmd_o2 = 1'b0;
    logic [7:0]  cmd_data = 8'h00;
    logic        shdn_n = 1'b1;
    logic [15:0] wiper_code;
    logic [1:0]  code_vld;
    logic        sd_active, gpo1, gpo2;
    logic [7:0]  rd_data;
    logic [7:0]  s_code;
    logic [0:0]  s_vld;
    logic        s_sd, s_o1, s_o2;
    logic [7:0]  s_rd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wpot_bank dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_sel(cmd_sel),
        .cmd_mid(cmd_mid), .cmd_sd(cmd_sd), .cmd_o1(cmd_o1), .cmd_o2(cmd_o2),
        .cmd_data(cmd_data), .shdn_n(shdn_n), .wiper_code(wiper_code),
        .code_vld(code_vld), .sd_active(sd_active), .gpo1(gpo1), .gpo2(gpo2),
        .rd_data(rd_data)
    );

    wpot_bank #(.NUM_CH(1)) dut_single (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_sel(cmd_sel),
        .cmd_mid(cmd_mid), .cmd_sd(cmd_sd), .cmd_o1(cmd_o1), .cmd_o2(cmd_o2),
        .cmd_data(cmd_data), .shdn_n(shdn_n), .wiper_code(s_code),
        .code_vld(s_vld), .sd_active(s_sd), .gpo1(s_o1), .gpo2(s_o2),
        .rd_data(s_rd)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Apply one write on a falling edge; return at the next falling edge
    task automatic wr(input logic sel, input logic mid, input logic sd,
                      input logic o1, input logic o2, input logic [7:0] d);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_sel = sel; cmd_mid = mid; cmd_sd = sd;
        cmd_o1 = o1; cmd_o2 = o2; cmd_data = d;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ch0 code", wiper_code[7:0], 8'h80);
        check("R1 ch1 code", wiper_code[15:8], 8'h80);
        check("R1 gpo", {gpo1, gpo2}, 2'b00);
        check("R1 sd", sd_active, 1'b0);
        check("R1 vld", code_vld, 2'b00);
        check("R1 rd", rd_data, 8'h80);
        check("R1 single code", s_code, 8'h80);
    endtask

    task automatic t_write_select();
        wr(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C);
        check("R2 ch0 load", wiper_code[7:0], 8'h3C);
        check("R4 ch1 untouched", wiper_code[15:8], 8'h80);
        check("R9 vld ch0 pulse", code_vld, 2'b01);
        check("R10 rd ch0", rd_data, 8'h3C);
        @(negedge clk);
        check("R9 vld drops", code_vld, 2'b00);
        check("R2 ch0 holds", wiper_code[7:0], 8'h3C);
        wr(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hF1);
        check("R4 ch1 load", wiper_code[15:8], 8'hF1);
        check("R4 ch0 untouched", wiper_code[7:0], 8'h3C);
        check("R10 rd ch1", rd_data, 8'hF1);
        check("R8 gpo 10", {gpo1, gpo2}, 2'b10);
        check("R4 single ignores sel", s_code, 8'hF1);
        check("R9 single vld", s_vld, 1'b1);
    endtask

    task automatic t_same_value();
        wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hF1);
        check("R9 no pulse on same code", code_vld, 2'b00);
        check("R8 gpo 01", {gpo1, gpo2}, 2'b01);
        wr(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        check("R2 load 00", wiper_code[7:0], 8'h00);
        wr(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF);
        check("R2 load FF", wiper_code[7:0], 8'hFF);
        check("R8 gpo 11", {gpo1, gpo2}, 2'b11);
    endtask

    task automatic t_midscale();
        wr(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h11);
        check("R3 midscale ch0", wiper_code[7:0], 8'h80);
        check("R3 ch1 untouched", wiper_code[15:8], 8'hF1);
        check("R9 vld on midscale", code_vld, 2'b01);
        check("R3 single midscale", s_code, 8'h80);
    endtask

    task automatic t_soft_shutdown();
        wr(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h55);
        check("R5 sd set", sd_active, 1'b1);
        check("R5 code still loads", wiper_code[7:0], 8'h55);
        repeat (5) @(negedge clk);
        check("R5 sd latched", sd_active, 1'b1);
        check("R10 rd in shutdown", rd_data, 8'h55);
        check("R7 ch1 kept in shutdown", wiper_code[15:8], 8'hF1);
        wr(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h55);
        check("R5 sd cleared", sd_active, 1'b0);
        check("R7 ch0 after exit", wiper_code[7:0], 8'h55);
    endtask

    task automatic t_pin_shutdown();
        @(negedge clk);
        shdn_n = 1'b0;
        #1;
        check("R6 pin sd no clock", sd_active, 1'b1);
        repeat (4) @(negedge clk);
        check("R7 ch0 kept under pin", wiper_code[7:0], 8'h55);
        check("R7 ch1 kept under pin", wiper_code[15:8], 8'hF1);
        check("R10 rd under pin", rd_data, 8'h55);
        shdn_n = 1'b1;
        #1;
        check("R6 pin release", sd_active, 1'b0);
        @(negedge clk);
        check("R7 ch0 restored", wiper_code[7:0], 8'h55);
        wr(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h55);
        shdn_n = 1'b0;
        #1;
        shdn_n = 1'b1;
        #1;
        check("R6 sw latch keeps sd", sd_active, 1'b1);
        wr(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h55);
        check("R5 sd off", sd_active, 1'b0);
    endtask

    initial begin
        t_reset();
        t_write_select();
        t_same_value();
        t_midscale();
        t_soft_shutdown();
        t_pin_shutdown();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule